// File: doc/BRIEF.md
# Multi-Mode Time-of-Day Setting Controller

This block keeps a 24-hour time of day as three two-digit BCD fields: hours, minutes and seconds. It advances by one second on each single-cycle pulse of a 1 Hz enable input. Two level switches choose one of four operating modes: run, time adjustment, alarm setting and timer setting. One pushbutton moves an edit pointer over the hour, minute and second fields. The field under the pointer steps up by one on every 1 Hz enable, so the user holds the mode and watches the digits climb.

The block drives the live time, the stored alarm time, the decoded mode and the edit pointer. A display multiplexer can pick its source from these. Tone generation, the countdown datapath, display scanning and the clock dividers sit outside this block.

Top module: `clock_set_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the time to 00:00:00, the alarm to 00:00:00, the mode to run (code 0) and the edit pointer to idle (code 0).
- R2: The mode output is decoded from the switch pair {mode_sel_a, mode_sel_b}: 11 gives run (code 0), 00 gives adjust (code 1), 01 gives alarm setting (code 2) and 10 gives timer setting (code 3).
- R3: Outside adjust mode, each 1 Hz enable adds one second with full carry. Seconds wrap 59→00 into minutes, minutes wrap 59→00 into hours, and 23:59:59 becomes 00:00:00. Every digit always holds a legal BCD value.
- R4: Without an enable the time holds. In run mode the key has no effect and the edit pointer stays idle.
- R5: In adjust, alarm and timer modes, each key press moves the edit pointer through the codes idle(0) → hour(1) → minute(2) → second(3) → hour(1) and so on.
- R6: In adjust mode, each enable adds one to the selected time field only. Hours wrap 23→00 and minutes and seconds wrap 59→00, with no carry into other fields. With no field selected, the time holds.
- R7: In alarm mode, each enable adds one to the selected alarm field with the same wrap rules, while the time keeps running. In every other mode the alarm registers hold.
- R8: Any change of the decoded mode puts the edit pointer back to idle.
- R9: The key is synchronised and edge-detected, so a press held for many cycles moves the pointer by exactly one step.
- R10: In timer mode the pointer cycles but no alarm field changes, and the time keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1hz | input | 1 | One-cycle pulse per second |
| mode_sel_a | input | 1 | First mode switch |
| mode_sel_b | input | 1 | Second mode switch |
| step_key | input | 1 | Edit-step pushbutton, high while pressed, asynchronous |
| time_hh | output | 8 | Time hours, BCD |
| time_mm | output | 8 | Time minutes, BCD |
| time_ss | output | 8 | Time seconds, BCD |
| alarm_hh | output | 8 | Alarm hours, BCD |
| alarm_mm | output | 8 | Alarm minutes, BCD |
| alarm_ss | output | 8 | Alarm seconds, BCD |
| mode | output | 2 | Decoded mode code |
| edit_field | output | 2 | Edit pointer code |

## Verification
The midnight rollover is the hardest case to reach, because from reset the ports only let time run forward one second per enable. The stimulus therefore uses adjust mode to raise hours, minutes and seconds to 23:59:59 independently. Along the way it confirms that no carry leaks between fields. It then switches to run and applies one enable. The same path also covers the hour wrap 23→00 under adjustment and the one-step response to a key held for dozens of cycles.

// File: rtl/clkset_pkg.sv
package clkset_pkg;

    localparam int DIGIT_W = 4;
    localparam int FIELD_W = 2 * DIGIT_W;

    typedef logic [FIELD_W-1:0] bcd2_t;

    typedef enum logic [1:0] {
        MODE_RUN    = 2'd0,
        MODE_ADJUST = 2'd1,
        MODE_ALARM  = 2'd2,
        MODE_TIMER  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        FLD_NONE = 2'd0,
        FLD_HOUR = 2'd1,
        FLD_MIN  = 2'd2,
        FLD_SEC  = 2'd3
    } field_e;

    typedef struct packed {
        bcd2_t hh;
        bcd2_t mm;
        bcd2_t ss;
    } hms_t;

    localparam bcd2_t LAST_HOUR = 8'h23;
    localparam bcd2_t LAST_MS   = 8'h59;

    function automatic mode_e decode_mode(input logic a, input logic b);
        case ({a, b})
            2'b11:   return MODE_RUN;
            2'b00:   return MODE_ADJUST;
            2'b01:   return MODE_ALARM;
            default: return MODE_TIMER;
        endcase
    endfunction

    function automatic bcd2_t bcd_step(input bcd2_t v, input bcd2_t last);
        logic [DIGIT_W-1:0] hi;
        logic [DIGIT_W-1:0] lo;
        hi = v[FIELD_W-1:DIGIT_W];
        lo = v[DIGIT_W-1:0];
        if (v == last) begin
            return '0;
        end else if (lo == 4'd9) begin
            return {hi + 4'd1, 4'd0};
        end else begin
            return {hi, lo + 4'd1};
        end
    endfunction

    function automatic field_e next_field(input field_e f);
        case (f)
            FLD_NONE: return FLD_HOUR;
            FLD_HOUR: return FLD_MIN;
            FLD_MIN:  return FLD_SEC;
            default:  return FLD_HOUR;
        endcase
    endfunction

endpackage

// File: rtl/key_edge.sv
module key_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic key_raw,
    output logic key_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= key_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign key_pulse = sync_q[STAGES-1] & ~prev_q;

    AST_ONE_STEP_PER_PRESS: assert property (@(posedge clk) disable iff (rst)
        key_pulse |=> !key_pulse); // R9

endmodule

// File: rtl/mode_ctl.sv
module mode_ctl
    import clkset_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sel_a,
    input  logic   sel_b,
    input  logic   key_pulse,
    output mode_e  mode_q,
    output field_e field_q
);
    mode_e want_mode;

    always_comb want_mode = decode_mode(sel_a, sel_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_RUN;
            field_q <= FLD_NONE;
        end else if (want_mode != mode_q) begin
            mode_q  <= want_mode;
            field_q <= FLD_NONE;
        end else if (key_pulse && mode_q != MODE_RUN) begin
            field_q <= next_field(field_q);
        end
    end

    AST_RUN_POINTER_IDLE: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RUN) |-> (field_q == FLD_NONE)); // R4
    AST_SWITCH_CLEARS_POINTER: assert property (@(posedge clk) disable iff (rst)
        (want_mode != mode_q) |=> (field_q == FLD_NONE)); // R8

endmodule

// File: rtl/time_keeper.sv
module time_keeper
    import clkset_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  mode_e  mode,
    input  field_e field,
    output hms_t   now_q,
    output hms_t   alarm_q
);
    hms_t now_d;
    hms_t alarm_d;

    always_comb begin
        now_d = now_q;
        if (tick) begin
            if (mode == MODE_ADJUST) begin
                case (field)
                    FLD_HOUR: now_d.hh = bcd_step(now_q.hh, LAST_HOUR);
                    FLD_MIN:  now_d.mm = bcd_step(now_q.mm, LAST_MS);
                    FLD_SEC:  now_d.ss = bcd_step(now_q.ss, LAST_MS);
                    default:  now_d = now_q;
                endcase
            end else begin
                now_d.ss = bcd_step(now_q.ss, LAST_MS);
                if (now_q.ss == LAST_MS) begin
                    now_d.mm = bcd_step(now_q.mm, LAST_MS);
                    if (now_q.mm == LAST_MS) begin
                        now_d.hh = bcd_step(now_q.hh, LAST_HOUR);
                    end
                end
            end
        end
    end

    always_comb begin
        alarm_d = alarm_q;
        if (tick && mode == MODE_ALARM) begin
            case (field)
                FLD_HOUR: alarm_d.hh = bcd_step(alarm_q.hh, LAST_HOUR);
                FLD_MIN:  alarm_d.mm = bcd_step(alarm_q.mm, LAST_MS);
                FLD_SEC:  alarm_d.ss = bcd_step(alarm_q.ss, LAST_MS);
                default:  alarm_d = alarm_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q   <= '0;
            alarm_q <= '0;
        end else begin
            now_q   <= now_d;
            alarm_q <= alarm_d;
        end
    end

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(now_q)); // R4
    AST_BCD_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (now_q.ss <= LAST_MS) && (now_q.mm <= LAST_MS) && (now_q.hh <= LAST_HOUR)
        && (now_q.ss[3:0] <= 4'd9) && (now_q.mm[3:0] <= 4'd9) && (now_q.hh[3:0] <= 4'd9)); // R3
    AST_ALARM_ONLY_WHEN_SETTING: assert property (@(posedge clk) disable iff (rst)
        !(tick && mode == MODE_ALARM) |=> $stable(alarm_q)); // R7
    AST_ADJUST_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == MODE_ADJUST && field == FLD_MIN) |=> ($stable(now_q.hh) && $stable(now_q.ss))); // R6

endmodule

// File: rtl/clock_set_ctrl.sv
module clock_set_ctrl
    import clkset_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1hz,
    input  logic       mode_sel_a,
    input  logic       mode_sel_b,
    input  logic       step_key,
    output logic [7:0] time_hh,
    output logic [7:0] time_mm,
    output logic [7:0] time_ss,
    output logic [7:0] alarm_hh,
    output logic [7:0] alarm_mm,
    output logic [7:0] alarm_ss,
    output logic [1:0] mode,
    output logic [1:0] edit_field
);
    logic   key_pulse;
    mode_e  mode_w;
    field_e field_w;
    hms_t   now_w;
    hms_t   alarm_w;

    key_edge #(.STAGES(SYNC_STAGES)) u_key (
        .clk       (clk),
        .rst       (rst),
        .key_raw   (step_key),
        .key_pulse (key_pulse)
    );

    mode_ctl u_mode (
        .clk       (clk),
        .rst       (rst),
        .sel_a     (mode_sel_a),
        .sel_b     (mode_sel_b),
        .key_pulse (key_pulse),
        .mode_q    (mode_w),
        .field_q   (field_w)
    );

    time_keeper u_time (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_1hz),
        .mode    (mode_w),
        .field   (field_w),
        .now_q   (now_w),
        .alarm_q (alarm_w)
    );

    assign time_hh    = now_w.hh;
    assign time_mm    = now_w.mm;
    assign time_ss    = now_w.ss;
    assign alarm_hh   = alarm_w.hh;
    assign alarm_mm   = alarm_w.mm;
    assign alarm_ss   = alarm_w.ss;
    assign mode       = mode_w;
    assign edit_field = field_w;

endmodule

// File: tb/clock_set_ctrl_tb.sv
module clock_set_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       mode_sel_a = 1'b1;
    logic       mode_sel_b = 1'b1;
    logic       step_key = 1'b0;
    logic [7:0] time_hh, time_mm, time_ss;
    logic [7:0] alarm_hh, alarm_mm, alarm_ss;
    logic [1:0] mode, edit_field;

    always #4 clk = ~clk;

    clock_set_ctrl u_dut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz),
        .mode_sel_a(mode_sel_a), .mode_sel_b(mode_sel_b), .step_key(step_key),
        .time_hh(time_hh), .time_mm(time_mm), .time_ss(time_ss),
        .alarm_hh(alarm_hh), .alarm_mm(alarm_mm), .alarm_ss(alarm_ss),
        .mode(mode), .edit_field(edit_field)
    );

    typedef struct {
        string      req;
        logic [23:0] tm;
        logic [23:0] al;
        logic [1:0]  md;
        logic [1:0]  fd;
    } exp_t;

    exp_t exp_q[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int th = 0, tmin = 0, ts = 0;
    int ah = 0, amin = 0, asec = 0;
    int m_mode = 0, m_field = 0;

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) * 16) + (v % 10));
    endfunction

    // monitor: pops one expected item and compares it to the ports
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            exp_t e;
            logic [23:0] at, aa;
            e  = exp_q.pop_front();
            at = {time_hh, time_mm, time_ss};
            aa = {alarm_hh, alarm_mm, alarm_ss};
            n_tests++;
            if (at !== e.tm || aa !== e.al || mode !== e.md || edit_field !== e.fd) begin
                n_fail++;
                $display("FAIL %s: time=%h alarm=%h mode=%0d field=%0d expected time=%h alarm=%h mode=%0d field=%0d",
                         e.req, at, aa, mode, edit_field, e.tm, e.al, e.md, e.fd);
            end
        end
    end

    task automatic check(input string req);
        exp_t e;
        e.req = req;
        e.tm  = {to_bcd(th), to_bcd(tmin), to_bcd(ts)};
        e.al  = {to_bcd(ah), to_bcd(amin), to_bcd(asec)};
        e.md  = 2'(m_mode);
        e.fd  = 2'(m_field);
        exp_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        #1;
    endtask

    task automatic set_mode(input logic a, input logic b);
        int nm;
        mode_sel_a = a;
        mode_sel_b = b;
        case ({a, b})
            2'b11:   nm = 0;
            2'b00:   nm = 1;
            2'b01:   nm = 2;
            default: nm = 3;
        endcase
        if (nm != m_mode) begin
            m_mode  = nm;
            m_field = 0;
        end
        settle();
    endtask

    task automatic press_key(input int hold);
        step_key = 1'b1;
        repeat (hold) @(posedge clk);
        #1;
        step_key = 1'b0;
        settle();
        if (m_mode != 0) m_field = (m_field == 3) ? 1 : m_field + 1;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            tick_1hz = 1'b1;
            @(posedge clk);
            #1;
            tick_1hz = 1'b0;
            repeat (2) @(posedge clk);
            #1;
            if (m_mode == 1) begin
                case (m_field)
                    1: th = (th + 1) % 24;
                    2: tmin = (tmin + 1) % 60;
                    3: ts = (ts + 1) % 60;
                    default: ;
                endcase
            end else begin
                ts++;
                if (ts == 60) begin
                    ts = 0;
                    tmin++;
                    if (tmin == 60) begin
                        tmin = 0;
                        th = (th + 1) % 24;
                    end
                end
            end
            if (m_mode == 2) begin
                case (m_field)
                    1: ah = (ah + 1) % 24;
                    2: amin = (amin + 1) % 60;
                    3: asec = (asec + 1) % 60;
                    default: ;
                endcase
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        settle();
        check("R1 reset state");

        tick(3);
        check("R3 run mode counts seconds");
        press_key(5);
        check("R4 key ignored in run mode");
        repeat (20) @(posedge clk);
        #1;
        check("R4 time holds without tick");

        set_mode(1'b0, 1'b0);
        check("R2 adjust mode code");
        tick(2);
        check("R6 adjust with idle pointer holds time");
        press_key(40);
        check("R9 long press advances one step to hour");
        tick(23);
        check("R6 hour field adjusted to 23");
        tick(1);
        check("R6 hour wraps 23 to 00");
        tick(23);
        press_key(4);
        check("R5 pointer hour to minute");
        tick(59);
        check("R6 minute adjusted to 59 without carry");
        press_key(4);
        check("R5 pointer minute to second");
        tick(56);
        check("R6 second adjusted to 59 without carry");
        press_key(4);
        check("R5 pointer second back to hour");

        set_mode(1'b1, 1'b1);
        check("R8 return to run clears pointer");
        tick(1);
        check("R3 23:59:59 rolls to 00:00:00");
        tick(61);
        check("R3 seconds carry into minutes");

        set_mode(1'b0, 1'b1);
        check("R2 alarm mode code");
        press_key(4);
        tick(5);
        check("R7 alarm hour set while time runs");
        press_key(4);
        press_key(4);
        tick(2);
        check("R7 alarm second set");

        set_mode(1'b1, 1'b0);
        check("R8 timer mode entry clears pointer");
        press_key(4);
        check("R5 timer mode pointer steps to hour");
        tick(3);
        check("R10 timer mode leaves alarm alone and time runs");
        set_mode(1'b0, 1'b1);
        check("R8 alarm mode re-entry clears pointer");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule